// File: doc/BRIEF.md
# Aggregated Receive Buffer Splitter

This block turns one aggregated receive transfer into a stream of per-frame descriptors. The transfer is a byte buffer, reached through a synchronous read port with one cycle of latency. It holds several Ethernet frames back to back, followed by a table of 32-bit per-frame headers and a final 32-bit trailer. On a start strobe the block latches the buffer length and reads the trailer. The trailer gives the number of frames and where the header table begins. The block then reads the headers one at a time. For each frame it offers a descriptor with the payload offset, the length and the error flags on a valid/ready output.

Frame data is not moved. A consumer uses the offset and length to fetch the payload from the same buffer. A data pointer starts at byte 0, and each frame's payload sits 2 bytes past it. After each frame the pointer moves on by the frame length rounded up to a multiple of 8. When the work ends, whether all frames were sent or the buffer was rejected, the block pulses `done` and holds a status code until the next start.

The controller has five states. IDLE waits for start. TRAILER fetches the trailer. HEADER fetches one header. EMIT offers a descriptor. DONE is a one-cycle completion state. The transitions are:
- IDLE to DONE on a start with a short buffer.
- IDLE to TRAILER on any other start.
- TRAILER to DONE when the count is zero or the table offset is out of range.
- TRAILER to HEADER when the trailer is valid.
- HEADER to DONE when the frame overruns the table.
- HEADER to EMIT when the frame fits.
- EMIT to HEADER on a handshake while frames remain.
- EMIT to DONE on the handshake of the last frame.
- DONE to IDLE, always.

Top module: `rxd_deagg`

## Requirements
- R1: During and straight after reset, `desc_valid` and `done` are low and `status` is 0.
- R2: The trailer is the last 4 bytes of the buffer, read as a little-endian word. Its bits 15:0 are the frame count and its bits 31:16 are the byte offset of the header table.
- R3: A buffer length below 4 ends the job with `status` = 1 (size error) and no descriptor.
- R4: A frame count of 0 ends the job with `status` = 0 and no descriptor.
- R5: A table offset greater than the buffer length minus 4 ends the job with `status` = 2 (I/O error) and no descriptor. An offset equal to the length minus 4 is accepted.
- R6: Each header is a little-endian 32-bit word. The frame length is bits 28:16, and no other header bit affects it.
- R7: The data pointer starts at 0 and the descriptor offset is the pointer plus 2. After each frame the pointer advances by (length+7) with the low 3 bits cleared, and the header address advances by 4.
- R8: The flags are copied from the header: bit 29 to `desc_crc_err`, bit 31 to `desc_drop`, bits 4:2 to `desc_l4_type` (1 = UDP, 4 = TCP), bit 1 to `desc_l3_err` and bit 0 to `desc_l4_err`. Flagged frames are still emitted.
- R9: While `desc_valid` is high and `desc_ready` is low, the descriptor stays valid and unchanged.
- R10: After exactly the counted number of handshakes, `done` pulses with `status` = 0.
- R11: A frame whose pointer plus length exceeds the table offset is not emitted. The job ends with `status` = 3 (malformed), and earlier frames are delivered first.
- R12: `start` is ignored unless the block is idle, and the buffer length is taken only when the start is accepted.
- R13: `done` lasts exactly one cycle and is never high together with `desc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin splitting a buffer (taken only when idle) |
| buf_len | input | ADDR_W | Buffer length in bytes, sampled with start |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | ADDR_W | Buffer byte address |
| rd_data | input | 8 | Byte read back one cycle after the address |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_offset | output | ADDR_W | Payload start offset in the buffer |
| desc_len | output | 13 | Frame length in bytes |
| desc_crc_err | output | 1 | CRC error flag |
| desc_drop | output | 1 | Drop flag |
| desc_l4_type | output | 3 | Layer-4 type code |
| desc_l3_err | output | 1 | L3 checksum error flag |
| desc_l4_err | output | 1 | L4 checksum error flag |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 size, 2 I/O, 3 malformed; held until next start |

## Verification
The bench builds buffers in which the last frame ends exactly on the header table. A design with an off-by-one overrun test would abort that buffer as malformed. It also uses a table offset exactly equal to the length minus 4. There the header is the trailer word itself, and a design that rejects equality would report an I/O error instead of one frame. Frame lengths of 60 and 8 check the rounding: a design that advances by the raw length would place the next payloads at 62 and 70 instead of 66 and 74. A second start with a short length, given in the middle of a job, would turn the result into a size error if it were wrongly accepted. Throttled ready shows whether a design changes or drops a descriptor that has not been taken.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int LEN_W       = 13;
    localparam int HDR_LEN_LSB = 16;
    localparam int ALIGN       = 8;
    localparam int PAD         = 2;
    localparam int WORD_BYTES  = 4;
    localparam int FIELD_W     = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TRAILER,
        S_HEADER,
        S_EMIT,
        S_DONE
    } rxd_state_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_SIZE      = 2'd1,
        ST_IO        = 2'd2,
        ST_MALFORMED = 2'd3
    } rxd_status_e;

    typedef struct packed {
        logic       crc_err;
        logic       drop;
        logic [2:0] l4_type;
        logic       l3_err;
        logic       l4_err;
    } rxd_flags_t;

    function automatic rxd_flags_t unpack_flags(input logic [31:0] w);
        rxd_flags_t f;
        f.crc_err = w[29];
        f.drop    = w[31];
        f.l4_type = w[4:2];
        f.l3_err  = w[1];
        f.l4_err  = w[0];
        return f;
    endfunction
endpackage

// File: rtl/rxd_word_fetch.sv
module rxd_word_fetch #(
    parameter int ADDR_W = 16,
    parameter int BYTES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [ADDR_W-1:0]    base,
    output logic                 rd_en,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [7:0]           rd_data,
    output logic                 word_valid,
    output logic [8*BYTES-1:0]   word
);
    localparam int CNT_W = $clog2(BYTES + 1);

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            base_q     <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (go && !busy) begin
                busy   <= 1'b1;
                cnt    <= '0;
                base_q <= base;
            end else if (busy) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (cnt == CNT_W'(b + 1)) word[8*b +: 8] <= rd_data;
                end
                if (cnt == CNT_W'(BYTES)) begin
                    busy       <= 1'b0;
                    word_valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign rd_en   = busy && (cnt < CNT_W'(BYTES));
    assign rd_addr = base_q + ADDR_W'(cnt);
endmodule

// File: rtl/rxd_frame_step.sv
module rxd_frame_step
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] data_ptr,
    input  logic [31:0]       hdr_word,
    input  logic [ADDR_W-1:0] tbl_off,
    output logic [LEN_W-1:0]  frm_len,
    output rxd_flags_t        flags,
    output logic [ADDR_W-1:0] pay_off,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              overrun
);
    localparam int EXT_W  = ADDR_W + 1;
    localparam int STEP_W = LEN_W + 1;

    logic [STEP_W-1:0] rounded;
    logic [EXT_W-1:0]  frm_end;
    logic              unused_bits;

    always_comb begin
        frm_len  = hdr_word[HDR_LEN_LSB +: LEN_W];
        rounded  = (STEP_W'(frm_len) + STEP_W'(ALIGN - 1)) & ~STEP_W'(ALIGN - 1);
        frm_end  = EXT_W'(data_ptr) + EXT_W'(frm_len);
        overrun  = frm_end > EXT_W'(tbl_off);
        pay_off  = data_ptr + ADDR_W'(PAD);
        next_ptr = data_ptr + ADDR_W'(rounded);
        flags    = unpack_flags(hdr_word);
    end

    assign unused_bits = ^{hdr_word[30], hdr_word[15:5]};
endmodule

// File: rtl/rxd_deagg.sv
module rxd_deagg
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] buf_len,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [ADDR_W-1:0] desc_offset,
    output logic [LEN_W-1:0]  desc_len,
    output logic              desc_crc_err,
    output logic              desc_drop,
    output logic [2:0]        desc_l4_type,
    output logic              desc_l3_err,
    output logic              desc_l4_err,
    output logic              done,
    output logic [1:0]        status
);
    localparam int CMP_W = ((ADDR_W > FIELD_W) ? ADDR_W : FIELD_W) + 1;

    rxd_state_e  state_q, state_d;
    rxd_status_e fin_d, status_q;

    logic                  fetch_go;
    logic [ADDR_W-1:0]     fetch_base;
    logic                  word_valid;
    logic [31:0]           word;

    logic [ADDR_W-1:0]     len_q, tbl_off_q, hdr_ptr_q, ptr_q, nxt_q;
    logic [FIELD_W-1:0]    left_q;
    logic [ADDR_W-1:0]     off_q;
    logic [LEN_W-1:0]      dlen_q;
    rxd_flags_t            flags_q;

    logic [FIELD_W-1:0]    trl_cnt, trl_off;
    logic                  trl_off_bad, short_buf;

    logic [LEN_W-1:0]      st_len;
    rxd_flags_t            st_flags;
    logic [ADDR_W-1:0]     st_pay, st_next;
    logic                  st_overrun;

    rxd_word_fetch #(.ADDR_W(ADDR_W), .BYTES(WORD_BYTES)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fetch_go),
        .base       (fetch_base),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .word_valid (word_valid),
        .word       (word)
    );

    rxd_frame_step #(.ADDR_W(ADDR_W)) u_step (
        .data_ptr (ptr_q),
        .hdr_word (word),
        .tbl_off  (tbl_off_q),
        .frm_len  (st_len),
        .flags    (st_flags),
        .pay_off  (st_pay),
        .next_ptr (st_next),
        .overrun  (st_overrun)
    );

    assign trl_cnt     = word[FIELD_W-1:0];
    assign trl_off     = word[2*FIELD_W-1:FIELD_W];
    assign trl_off_bad = CMP_W'(trl_off) > (CMP_W'(len_q) - CMP_W'(WORD_BYTES));
    assign short_buf   = buf_len < ADDR_W'(WORD_BYTES);

    // Next state, completion code and fetch requests
    always_comb begin
        state_d    = state_q;
        fin_d      = ST_OK;
        fetch_go   = 1'b0;
        fetch_base = hdr_ptr_q + ADDR_W'(WORD_BYTES);
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (short_buf) begin
                        state_d = S_DONE;
                        fin_d   = ST_SIZE;
                    end else begin
                        state_d    = S_TRAILER;
                        fetch_go   = 1'b1;
                        fetch_base = buf_len - ADDR_W'(WORD_BYTES);
                    end
                end
            end
            S_TRAILER: begin
                if (word_valid) begin
                    if (trl_cnt == '0) begin
                        state_d = S_DONE;
                    end else if (trl_off_bad) begin
                        state_d = S_DONE;
                        fin_d   = ST_IO;
                    end else begin
                        state_d    = S_HEADER;
                        fetch_go   = 1'b1;
                        fetch_base = ADDR_W'(trl_off);
                    end
                end
            end
            S_HEADER: begin
                if (word_valid) begin
                    if (st_overrun) begin
                        state_d = S_DONE;
                        fin_d   = ST_MALFORMED;
                    end else begin
                        state_d = S_EMIT;
                    end
                end
            end
            S_EMIT: begin
                if (desc_ready) begin
                    if (left_q == FIELD_W'(1)) begin
                        state_d = S_DONE;
                    end else begin
                        state_d  = S_HEADER;
                        fetch_go = 1'b1;
                    end
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            tbl_off_q <= '0;
            hdr_ptr_q <= '0;
            ptr_q     <= '0;
            nxt_q     <= '0;
            left_q    <= '0;
            off_q     <= '0;
            dlen_q    <= '0;
            flags_q   <= '0;
            status_q  <= ST_OK;
        end else begin
            if (state_q == S_IDLE && start) begin
                len_q    <= buf_len;
                ptr_q    <= '0;
                status_q <= ST_OK;
            end
            if (state_d == S_DONE && state_q != S_DONE) status_q <= fin_d;
            if (state_q == S_TRAILER && state_d == S_HEADER) begin
                left_q    <= trl_cnt;
                tbl_off_q <= ADDR_W'(trl_off);
                hdr_ptr_q <= ADDR_W'(trl_off);
            end
            if (state_q == S_HEADER && state_d == S_EMIT) begin
                off_q   <= st_pay;
                dlen_q  <= st_len;
                flags_q <= st_flags;
                nxt_q   <= st_next;
            end
            if (state_q == S_EMIT && desc_ready) begin
                ptr_q     <= nxt_q;
                hdr_ptr_q <= hdr_ptr_q + ADDR_W'(WORD_BYTES);
                left_q    <= left_q - FIELD_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        desc_valid   = (state_q == S_EMIT);
        done         = (state_q == S_DONE);
        status       = status_q;
        desc_offset  = off_q;
        desc_len     = dlen_q;
        desc_crc_err = flags_q.crc_err;
        desc_drop    = flags_q.drop;
        desc_l4_type = flags_q.l4_type;
        desc_l3_err  = flags_q.l3_err;
        desc_l4_err  = flags_q.l4_err;
    end
endmodule

// File: rtl/rxd_deagg_chk.sv
module rxd_deagg_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [ADDR_W-1:0] desc_offset,
    input logic [12:0]       desc_len,
    input logic              done,
    input logic [1:0]        status
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!desc_valid && !done && status == 2'd0)
                else $error("R1 outputs not idle in reset");
        end
    end

    p_hold_desc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_offset) && $stable(desc_len)))
        else $error("R9 descriptor changed while stalled");

    p_offset_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_offset[2:0] == 3'd2))
        else $error("R7 offset not 2 past an 8-byte boundary");

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R13 done longer than one cycle");

    p_done_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && desc_valid))
        else $error("R13 done together with valid");
endmodule

bind rxd_deagg rxd_deagg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_offset (desc_offset),
    .desc_len    (desc_len),
    .done        (done),
    .status      (status)
);

// File: tb/rxd_deagg_tb.sv
module rxd_deagg_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] buf_len = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          desc_valid;
    logic          desc_ready = 1'b0;
    logic [AW-1:0] desc_offset;
    logic [12:0]   desc_len;
    logic          desc_crc_err, desc_drop, desc_l3_err, desc_l4_err;
    logic [2:0]    desc_l4_type;
    logic          done;
    logic [1:0]    status;

    logic [7:0] mem [0:4095];

    int errs = 0;
    int checks = 0;
    int n_got;
    int got_off [0:15];
    int got_len [0:15];
    int got_flg [0:15];
    int got_status;
    bit saw_done;

    always #5 clk = ~clk;

    always_ff @(posedge clk) rd_data <= mem[rd_addr[11:0]];

    rxd_deagg #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_len(buf_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_offset(desc_offset), .desc_len(desc_len),
        .desc_crc_err(desc_crc_err), .desc_drop(desc_drop),
        .desc_l4_type(desc_l4_type), .desc_l3_err(desc_l3_err),
        .desc_l4_err(desc_l4_err), .done(done), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) mem[a + b] = w[8*b +: 8];
    endtask

    // Runs one job; bp throttles ready; inj>0 pulses a second start at that cycle
    task automatic run(input int bl, input bit bp, input int inj);
        bit stall;
        int h_off, h_len;
        n_got = 0; saw_done = 0; got_status = -1; stall = 0; h_off = 0; h_len = 0;
        @(negedge clk);
        buf_len = AW'(bl); start = 1'b1; desc_ready = !bp;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 5000 && !saw_done; cyc++) begin
            if (inj != 0 && cyc == inj) begin start = 1'b1; buf_len = AW'(3); end
            else start = 1'b0;
            if (stall && desc_valid)
                chk(desc_offset == AW'(h_off) && int'(desc_len) == h_len,
                    "R9 stalled descriptor held", int'(desc_offset), h_off);
            if (bp) desc_ready = (cyc % 3 == 2);
            if (desc_valid && desc_ready && n_got < 16) begin
                got_off[n_got] = int'(desc_offset);
                got_len[n_got] = int'(desc_len);
                got_flg[n_got] = int'({desc_crc_err, desc_drop, desc_l4_type, desc_l3_err, desc_l4_err});
                n_got++;
            end
            stall = desc_valid && !desc_ready;
            h_off = int'(desc_offset); h_len = int'(desc_len);
            if (done) begin saw_done = 1; got_status = int'(status); end
            @(negedge clk);
        end
        start = 1'b0; desc_ready = 1'b0;
        chk(saw_done, "R10 job completes", int'(saw_done), 1);
    endtask

    // Three frames: lengths 60, 8, 16; table at 88; last frame ends on the table
    task automatic build_three;
        put_word(88, 32'h203C_0012);
        put_word(92, 32'hC008_0005);
        put_word(96, 32'h0010_0000);
        put_word(100, (32'd88 << 16) | 32'd3);
    endtask

    task automatic check_three(input string tag);
        chk(n_got == 3, {tag, " R10 frame count"}, n_got, 3);
        chk(got_status == 0, {tag, " R10 status ok"}, got_status, 0);
        chk(got_off[0] == 2 && got_off[1] == 66 && got_off[2] == 74,
            {tag, " R7 offsets"}, got_off[1] * 1000 + got_off[2], 66074);
        chk(got_len[0] == 60 && got_len[1] == 8 && got_len[2] == 16,
            {tag, " R6 lengths"}, got_len[0], 60);
        chk(got_flg[0] == 'h52, {tag, " R8 flags crc/tcp/l3"}, got_flg[0], 'h52);
        chk(got_flg[1] == 'h25, {tag, " R8 flags drop/udp/l4"}, got_flg[1], 'h25);
        chk(got_flg[2] == 0, {tag, " R8 no flags"}, got_flg[2], 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!desc_valid && !done, "R1 idle in reset", int'({desc_valid, done}), 0);
        chk(status == 2'd0, "R1 status zero in reset", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!desc_valid && !done && status == 2'd0, "R1 idle after reset",
            int'({desc_valid, done, status}), 0);
    endtask

    task automatic t_normal;
        build_three();
        run(104, 1'b0, 0);
        check_three("R2 basic");
    endtask

    task automatic t_backpressure;
        build_three();
        run(104, 1'b1, 0);
        check_three("R9 throttled");
    endtask

    task automatic t_start_busy;
        build_three();
        run(104, 1'b0, 6);
        check_three("R12 start ignored");
    endtask

    task automatic t_short;
        run(3, 1'b0, 0);
        chk(got_status == 1 && n_got == 0, "R3 length 3 size error", got_status, 1);
        run(0, 1'b0, 0);
        chk(got_status == 1 && n_got == 0, "R3 length 0 size error", got_status, 1);
    endtask

    task automatic t_zero_count;
        put_word(200, (32'd8 << 16));
        run(204, 1'b0, 0);
        chk(got_status == 0 && n_got == 0, "R4 zero count silent", n_got, 0);
    endtask

    task automatic t_bad_offset;
        put_word(8, (32'd9 << 16) | 32'd1);
        run(12, 1'b0, 0);
        chk(got_status == 2 && n_got == 0, "R5 offset past limit", got_status, 2);
        // Offset equal to length-4: header is the trailer word itself (len 8, l4 error bit)
        put_word(8, (32'd8 << 16) | 32'd1);
        run(12, 1'b0, 0);
        chk(got_status == 0 && n_got == 1, "R5 offset at limit accepted", got_status * 10 + n_got, 1);
        chk(got_off[0] == 2 && got_len[0] == 8 && got_flg[0] == 1, "R5 limit frame fields",
            got_len[0], 8);
    endtask

    task automatic t_malformed;
        put_word(48, 32'h0014_0000);
        put_word(52, 32'h001E_0000);
        put_word(56, (32'd48 << 16) | 32'd2);
        run(60, 1'b0, 0);
        chk(got_status == 3, "R11 overrun status", got_status, 3);
        chk(n_got == 1 && got_off[0] == 2 && got_len[0] == 20, "R11 earlier frame kept", n_got, 1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        t_reset();
        t_normal();
        t_backpressure();
        t_start_busy();
        t_short();
        t_zero_count();
        t_bad_offset();
        t_malformed();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule